// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a free-running event timer. It watches the shared 64-bit main count and the timer-wide run enable. It raises an interrupt when the count reaches the channel's comparator. A 32-bit register port lets software read and write the channel's configuration word and its comparator, and read its routing capability mask.

The channel runs in one of two modes. In one-shot mode it fires once and then stays quiet until software writes the comparator again. In periodic mode a hidden period register is added to the comparator on every match, so the channel fires at a fixed spacing without software help. The period register is loaded by writing the comparator while a self-clearing value-set flag is 1. The output can be a one-cycle pulse or a level that holds until software clears it. The channel can also be forced to compare and accumulate on the low 32 bits only.

Top module: `evt_cmp_channel`

## Requirements
- R1: After reset the configuration word reads back only its read-only flags: bit 4 = periodic capability, bit 5 = 64-bit capability, every other bit 0. Bits 14 and 15 (message delivery) always read 0. The comparator reads all ones, and irq_o and status_o are 0.
- R2: Registers are selected by byte offset: 0x00 configuration, 0x04 routing capability mask, 0x08 comparator low word, 0x0C comparator high word. The mask reads as the ROUTE_MASK parameter and ignores writes. Offsets 0x10 and above read 0.
- R3: Configuration bits 13:9 select the interrupt line, shown on line_o. A written line number n is accepted only if bit n of the routing mask is 1. Otherwise the previous line number is kept.
- R4: In one-shot mode (bit 3 = 0) the channel fires in the cycle the count equals the comparator. It does not fire again until either comparator word is written.
- R5: In edge mode (bit 1 = 0) a match drives irq_o high for exactly one cycle, starting the cycle after the match.
- R6: In level mode (bit 1 = 1) a match sets status_o. irq_o follows status_o until a one-cycle pulse on sts_clr_i clears it.
- R7: irq_o is 1 only while configuration bit 2 is 1. While run_i is 0 no match occurs, and a one-shot channel stays armed.
- R8: In periodic mode (bit 3 = 1) every match fires the interrupt and adds the period register to the comparator.
- R9: A comparator word written while bit 6 is 1 is loaded into both the comparator and the matching half of the period register. A comparator write with bit 6 = 0 leaves the period unchanged. Bit 6 reads 0 after any comparator write.
- R10: When the periodic capability is 0, writes of bit 3 are ignored and it reads 0.
- R11: In 32-bit operation (bit 8 = 1, or no 64-bit capability), only the low 32 bits of count and comparator are compared. The high comparator word reads 0 and ignores writes, and periodic accumulation wraps modulo 2^32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| count_i | input | 64 | Shared main count value |
| run_i | input | 1 | Timer-wide run enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write byte offset |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | ADDR_W | Read byte offset |
| rd_data_o | output | 32 | Read data (combinational) |
| sts_clr_i | input | 1 | Clears the level-mode status |
| irq_o | output | 1 | Interrupt output |
| status_o | output | 1 | Level-mode pending status |
| line_o | output | 5 | Selected interrupt line number |

## Verification
The hardest state to reach is a periodic channel whose period differs from its first target. Loading the period takes a value-set write to each half of the comparator, and then a plain write to move the target without touching the period. The bench drives that sequence and steps the count through several periods of randomly chosen length. It checks the output on every cycle, so gaps of the wrong length are caught. A second case puts the comparator near the 32-bit limit under forced 32-bit operation, so that accumulation must wrap.

// File: rtl/evt_cmp_pkg.sv
// Package: shared field positions, register indices and the configuration
// record of the comparator channel. Bit positions are decoded by software
// and must stay fixed.
package evt_cmp_pkg;
    localparam int BIT_LEVEL    = 1;
    localparam int BIT_IEN      = 2;
    localparam int BIT_PERIODIC = 3;
    localparam int BIT_PCAP     = 4;
    localparam int BIT_WCAP     = 5;
    localparam int BIT_VSET     = 6;
    localparam int BIT_FORCE32  = 8;
    localparam int LINE_LSB     = 9;
    localparam int LINE_W       = 5;

    localparam int IDX_CFG   = 0;
    localparam int IDX_ROUTE = 1;
    localparam int IDX_CLO   = 2;
    localparam int IDX_CHI   = 3;

    typedef struct packed {
        logic [LINE_W-1:0] line;
        logic              force32;
        logic              vset;
        logic              periodic;
        logic              ien;
        logic              level;
    } chan_cfg_t;
endpackage

// File: rtl/evt_cmp_cfg.sv
// Configuration register of one channel.
// Assumes: a single write port, so a configuration write and a comparator
// write never happen in the same cycle.
module evt_cmp_cfg
    import evt_cmp_pkg::*;
#(
    parameter int          WORD_W       = 32,
    parameter bit          PERIODIC_CAP = 1'b1,
    parameter logic [31:0] ROUTE_MASK   = 32'h0000_0F04
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we_i,
    input  logic              cmp_we_i,
    input  logic [WORD_W-1:0] wdata_i,
    output chan_cfg_t         cfg_o
);
    logic [LINE_W-1:0] line_req;
    assign line_req = wdata_i[LINE_LSB +: LINE_W];

    // Store written fields, gate periodic and line by capability, drop value-set after a comparator write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_o <= '0;
        end else if (cfg_we_i) begin
            cfg_o.level    <= wdata_i[BIT_LEVEL];
            cfg_o.ien      <= wdata_i[BIT_IEN];
            cfg_o.periodic <= wdata_i[BIT_PERIODIC] & PERIODIC_CAP;
            cfg_o.vset     <= wdata_i[BIT_VSET];
            cfg_o.force32  <= wdata_i[BIT_FORCE32];
            if (ROUTE_MASK[line_req])
                cfg_o.line <= line_req;
        end else if (cmp_we_i) begin
            cfg_o.vset <= 1'b0;
        end
    end

    assert_vset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_we_i |=> !cfg_o.vset);
    assert_periodic_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o.periodic |-> PERIODIC_CAP);
endmodule

// File: rtl/evt_cmp_match.sv
// Comparator, hidden period register and match detection.
// Assumes: count_i is the shared main count. In 32-bit operation the high
// halves take no part in matching and are held.
module evt_cmp_match #(
    parameter int WORD_W   = 32,
    parameter bit WIDE_CAP = 1'b1,
    localparam int CMP_W   = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMP_W-1:0]  count_i,
    input  logic              run_i,
    input  logic              we_lo_i,
    input  logic              we_hi_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              vset_i,
    input  logic              periodic_i,
    input  logic              force32_i,
    output logic [CMP_W-1:0]  cmp_view_o,
    output logic              fire_o
);
    logic             narrow;
    logic [CMP_W-1:0] cmp_all;
    logic [CMP_W-1:0] per_all;
    logic [CMP_W-1:0] per_eff;
    logic [CMP_W-1:0] cmp_next;
    logic             equal;
    logic             armed;

    assign narrow = force32_i || !WIDE_CAP;

    // Equality over the active width and the next periodic target.
    always_comb begin
        equal    = narrow ? (count_i[WORD_W-1:0] == cmp_all[WORD_W-1:0])
                          : (count_i == cmp_all);
        per_eff  = narrow ? {{WORD_W{1'b0}}, per_all[WORD_W-1:0]} : per_all;
        cmp_next = cmp_all + per_eff;
        if (narrow)
            cmp_next[CMP_W-1:WORD_W] = cmp_all[CMP_W-1:WORD_W];
    end

    assign fire_o     = run_i && equal && (periodic_i || armed);
    assign cmp_view_o = narrow ? {{WORD_W{1'b0}}, cmp_all[WORD_W-1:0]} : cmp_all;

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic              we_h;
        logic [WORD_W-1:0] cmp_h;
        logic [WORD_W-1:0] per_h;
        assign we_h = (h == 0) ? we_lo_i : (we_hi_i && !narrow);

        // Load this half on a write, or advance it by the period on a periodic match.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cmp_h <= '1;
                per_h <= '0;
            end else if (we_h) begin
                cmp_h <= wdata_i;
                if (vset_i)
                    per_h <= wdata_i;
            end else if (fire_o && periodic_i) begin
                cmp_h <= cmp_next[h*WORD_W +: WORD_W];
            end
        end
        assign cmp_all[h*WORD_W +: WORD_W] = cmp_h;
        assign per_all[h*WORD_W +: WORD_W] = per_h;
    end

    // Arm on any comparator write, disarm after a one-shot match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed <= 1'b0;
        else if (we_lo_i || we_hi_i)
            armed <= 1'b1;
        else if (fire_o && !periodic_i)
            armed <= 1'b0;
    end

    assert_oneshot_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && !periodic_i && !we_lo_i && !we_hi_i) |=> !fire_o);
    assert_run_blocks_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |-> !fire_o);
    assert_period_moves_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_o && periodic_i && per_eff != '0 && !we_lo_i && !we_hi_i)
        |=> cmp_all != $past(cmp_all));
endmodule

// File: rtl/evt_cmp_irq.sv
// Interrupt signalling: a one-cycle pulse in edge mode, or a held status
// in level mode. Everything is gated by the channel enable.
// Assumes: fire_i is high for the cycle of a match.
module evt_cmp_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic fire_i,
    input  logic level_i,
    input  logic ien_i,
    input  logic sts_clr_i,
    input  logic cfg_we_i,
    output logic irq_o,
    output logic status_o
);
    logic pulse;

    // Hold the level status, a match wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            status_o <= 1'b0;
        else if (fire_i && level_i)
            status_o <= 1'b1;
        else if (sts_clr_i)
            status_o <= 1'b0;
    end

    // One-cycle edge pulse after each edge-mode match.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pulse <= 1'b0;
        else
            pulse <= fire_i && !level_i;
    end

    assign irq_o = ien_i && (level_i ? status_o : pulse);

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ien_i);
    assert_level_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && level_i && !sts_clr_i && !cfg_we_i) |=> irq_o);
endmodule

// File: rtl/evt_cmp_channel.sv
// Top of one comparator channel: register decode, read mux, and the three
// sub-blocks. Reads are combinational. Byte offset bits 1:0 are ignored.
module evt_cmp_channel
    import evt_cmp_pkg::*;
#(
    parameter int          WORD_W       = 32,
    parameter int          ADDR_W       = 5,
    parameter bit          PERIODIC_CAP = 1'b1,
    parameter bit          WIDE_CAP     = 1'b1,
    parameter logic [31:0] ROUTE_MASK   = 32'h0000_0F04,
    localparam int         CMP_W        = 2 * WORD_W,
    localparam int         IDX_W        = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMP_W-1:0]  count_i,
    input  logic              run_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [WORD_W-1:0] wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [WORD_W-1:0] rd_data_o,
    input  logic              sts_clr_i,
    output logic              irq_o,
    output logic              status_o,
    output logic [LINE_W-1:0] line_o
);
    logic [IDX_W-1:0]  wr_idx, rd_idx;
    logic              cfg_we, we_lo, we_hi;
    chan_cfg_t         cfg;
    logic [CMP_W-1:0]  cmp_view;
    logic              fire;
    logic [WORD_W-1:0] cfg_word;

    assign wr_idx = wr_addr_i[ADDR_W-1:2];
    assign rd_idx = rd_addr_i[ADDR_W-1:2];
    assign cfg_we = wr_en_i && (wr_idx == IDX_W'(IDX_CFG));
    assign we_lo  = wr_en_i && (wr_idx == IDX_W'(IDX_CLO));
    assign we_hi  = wr_en_i && (wr_idx == IDX_W'(IDX_CHI));

    evt_cmp_cfg #(.WORD_W(WORD_W), .PERIODIC_CAP(PERIODIC_CAP), .ROUTE_MASK(ROUTE_MASK)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we_i(cfg_we), .cmp_we_i(we_lo || we_hi),
        .wdata_i(wr_data_i), .cfg_o(cfg));

    evt_cmp_match #(.WORD_W(WORD_W), .WIDE_CAP(WIDE_CAP)) u_match (
        .clk(clk), .rst_n(rst_n), .count_i(count_i), .run_i(run_i),
        .we_lo_i(we_lo), .we_hi_i(we_hi), .wdata_i(wr_data_i), .vset_i(cfg.vset),
        .periodic_i(cfg.periodic), .force32_i(cfg.force32),
        .cmp_view_o(cmp_view), .fire_o(fire));

    evt_cmp_irq u_irq (
        .clk(clk), .rst_n(rst_n), .fire_i(fire), .level_i(cfg.level), .ien_i(cfg.ien),
        .sts_clr_i(sts_clr_i), .cfg_we_i(cfg_we), .irq_o(irq_o), .status_o(status_o));

    assign line_o = cfg.line;

    // Assemble the configuration word with the fixed capability flags.
    always_comb begin
        cfg_word                       = '0;
        cfg_word[BIT_LEVEL]            = cfg.level;
        cfg_word[BIT_IEN]              = cfg.ien;
        cfg_word[BIT_PERIODIC]         = cfg.periodic;
        cfg_word[BIT_PCAP]             = PERIODIC_CAP;
        cfg_word[BIT_WCAP]             = WIDE_CAP;
        cfg_word[BIT_VSET]             = cfg.vset;
        cfg_word[BIT_FORCE32]          = cfg.force32;
        cfg_word[LINE_LSB +: LINE_W]   = cfg.line;
    end

    // Read multiplexer by register index.
    always_comb begin
        case (rd_idx)
            IDX_W'(IDX_CFG):   rd_data_o = cfg_word;
            IDX_W'(IDX_ROUTE): rd_data_o = ROUTE_MASK[WORD_W-1:0];
            IDX_W'(IDX_CLO):   rd_data_o = cmp_view[WORD_W-1:0];
            IDX_W'(IDX_CHI):   rd_data_o = cmp_view[CMP_W-1:WORD_W];
            default:           rd_data_o = '0;
        endcase
    end

    assert_line_allowed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (line_o != $past(line_o)) |-> ROUTE_MASK[line_o]);
endmodule

// File: tb/evt_cmp_channel_bench.sv
module evt_cmp_channel_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] count = '0;
    logic        run = 1'b0;
    logic        m_we = 1'b0, n_we = 1'b0;
    logic [4:0]  wr_addr = '0, rd_addr = '0;
    logic [31:0] wr_data = '0;
    logic        sts_clr = 1'b0;
    logic [31:0] m_rd, n_rd;
    logic        m_irq, n_irq, m_sts, n_sts;
    logic [4:0]  m_line, n_line;
    int checks = 0, errors = 0, cycles = 0;

    localparam logic [31:0] MASK = 32'h0000_0F04;
    localparam logic [31:0] IEN = 32'h4, LVL = 32'h2, PER = 32'h8, VS = 32'h40, F32 = 32'h100;
    localparam logic [31:0] L9 = 32'd9 << 9;

    always #5 clk = ~clk;

    evt_cmp_channel #(.ROUTE_MASK(MASK)) u_evt_cmp_channel (
        .clk(clk), .rst_n(rst_n), .count_i(count), .run_i(run), .wr_en_i(m_we),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(m_rd),
        .sts_clr_i(sts_clr), .irq_o(m_irq), .status_o(m_sts), .line_o(m_line));

    evt_cmp_channel #(.PERIODIC_CAP(1'b0), .WIDE_CAP(1'b0), .ROUTE_MASK(MASK)) u_evt_cmp_channel_narrow (
        .clk(clk), .rst_n(rst_n), .count_i(count), .run_i(run), .wr_en_i(n_we),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(n_rd),
        .sts_clr_i(sts_clr), .irq_o(n_irq), .status_o(n_sts), .line_o(n_line));

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input bit narrow, input logic [4:0] a, input logic [31:0] d);
        wr_addr = a; wr_data = d;
        if (narrow) n_we = 1'b1; else m_we = 1'b1;
        @(negedge clk);
        m_we = 1'b0; n_we = 1'b0;
    endtask

    task automatic rd(input bit narrow, input logic [4:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = narrow ? n_rd : m_rd;
    endtask

    task automatic step(input logic [63:0] v);
        count = v;
        @(negedge clk);
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL watchdog actual %0d expected below 100000", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(0, 5'h00, d); chk("R1 cfg main", d, 64'h30);
        rd(1, 5'h00, d); chk("R1 cfg narrow", d, 64'h0);
        rd(0, 5'h08, d); chk("R1 cmp lo", d, 64'hFFFF_FFFF);
        chk("R1 irq", {m_irq, m_sts}, 0);

        // R2 register map
        rd(0, 5'h04, d); chk("R2 mask", d, MASK);
        wr(0, 5'h04, 32'h0);
        rd(0, 5'h04, d); chk("R2 mask read-only", d, MASK);
        rd(0, 5'h10, d); chk("R2 beyond map", d, 0);

        // R3 line selection
        wr(0, 5'h00, L9);
        chk("R3 line accepted", m_line, 9);
        wr(0, 5'h00, 32'd5 << 9);
        chk("R3 line refused", m_line, 9);
        wr(0, 5'h00, IEN | L9);
        rd(0, 5'h00, d); chk("R3 line field", d[13:9], 9);

        // R4 R5 one-shot edge
        wr(0, 5'h0C, 0); wr(0, 5'h08, 100);
        run = 1'b1;
        step(99);  chk("R4 before match", m_irq, 0);
        step(100); chk("R5 pulse", m_irq, 1);
        step(101); chk("R5 one cycle", m_irq, 0);
        step(100); chk("R4 no refire", m_irq, 0);

        // R7 enable gating and run gating
        step(0);
        wr(0, 5'h00, L9); wr(0, 5'h08, 100);
        step(100); chk("R7 ien off", m_irq, 0);
        step(0);
        wr(0, 5'h00, IEN | L9); wr(0, 5'h08, 100);
        run = 1'b0;
        step(100); chk("R7 run off", m_irq, 0);
        step(101);
        run = 1'b1;
        step(100); chk("R7 stays armed", m_irq, 1);

        // R6 level mode
        step(0);
        wr(0, 5'h00, IEN | LVL | L9); wr(0, 5'h08, 200);
        step(200); chk("R6 level set", {m_irq, m_sts}, 3);
        step(201); chk("R6 level hold", m_irq, 1);
        step(202); chk("R6 level hold 2", m_irq, 1);
        sts_clr = 1'b1; step(203); sts_clr = 1'b0;
        chk("R6 cleared", {m_irq, m_sts}, 0);

        // R8 R9 periodic with value-set
        step(0);
        wr(0, 5'h00, IEN | PER | VS | L9); wr(0, 5'h08, 1000);
        rd(0, 5'h00, d); chk("R9 vset self-clear", d[6], 0);
        wr(0, 5'h00, IEN | PER | VS | L9); wr(0, 5'h0C, 0);
        rd(0, 5'h08, d); chk("R9 cmp lo loaded", d, 1000);
        step(1000); chk("R8 periodic fire", m_irq, 1);
        rd(0, 5'h08, d); chk("R8 period added", d, 2000);
        step(0);
        wr(0, 5'h08, 1500);
        step(1500); chk("R9 plain write fire", m_irq, 1);
        rd(0, 5'h08, d); chk("R9 period kept", d, 2500);

        // R8 random periods, every cycle checked
        for (int it = 0; it < 6; it++) begin
            int p;
            logic [63:0] b;
            p = 2 + int'($urandom % 30);
            b = 64'd5000 + 64'(it) * 64'd1000;
            step(0);
            wr(0, 5'h00, IEN | PER | VS | L9); wr(0, 5'h08, 32'(p));
            wr(0, 5'h00, IEN | PER | VS | L9); wr(0, 5'h0C, 0);
            wr(0, 5'h08, b[31:0]);
            for (int i = 0; i <= 4 * p; i++) begin
                step(b + 64'(i));
                chk("R8 random period", m_irq, (i % p) == 0);
            end
        end

        // R11 forced 32-bit with wrap
        step(0);
        wr(0, 5'h00, IEN | PER | VS | F32 | L9); wr(0, 5'h08, 32'h20);
        wr(0, 5'h08, 32'hFFFF_FFF0);
        rd(0, 5'h0C, d); chk("R11 hi reads zero", d, 0);
        wr(0, 5'h0C, 32'h55);
        rd(0, 5'h0C, d); chk("R11 hi write ignored", d, 0);
        step(64'h0000_0007_FFFF_FFF0); chk("R11 low-only match", m_irq, 1);
        rd(0, 5'h08, d); chk("R11 wrap", d, 32'h10);
        rd(0, 5'h0C, d); chk("R11 hi after wrap", d, 0);

        // R10 R11 no periodic, no 64-bit capability
        step(0);
        wr(1, 5'h00, IEN | PER);
        rd(1, 5'h00, d); chk("R10 periodic ignored", d, IEN);
        wr(1, 5'h0C, 1);
        rd(1, 5'h0C, d); chk("R11 narrow hi", d, 0);
        wr(1, 5'h08, 300);
        step(64'h0000_0009_0000_012C); chk("R11 narrow match", n_irq, 1);
        step(301); chk("R10 no repeat", n_irq, 0);
        step(300); chk("R10 one-shot only", n_irq, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule